// File: doc/BRIEF.md
# Programmable-Flag Offset Register Sequencer

This block keeps the two threshold values used by the programmable flags of a FIFO: the almost-empty distance (`n`) and the almost-full distance (`m`). Both values come from the FIFO data bus. A shared active-low select input turns the ordinary write and read strobes into offset accesses. A write strobe during select stores the low bits of the write bus into one offset register. A read strobe during select puts one offset onto a dedicated output bus, which the surrounding FIFO merges onto its data outputs.

Each path keeps its own one-bit pointer. The write-side pointer chooses the register that the next store updates. The read-side pointer chooses the register that the next readback presents. Both pointers start at the almost-empty register and move to the other register after every access. Readback is blocked while the FIFO runs in first-word-fall-through mode. During select, the memory write and read qualifiers are held off so that offset traffic never disturbs the FIFO storage. The current offsets feed the flag generator continuously.

Top module: `flag_offset_regs`

## Requirements
- R1: After reset, both offsets equal min(DEPTH/8 - 1, 127). With DEPTH=512 this value is 63. After reset, `ofs_q` is 0 and `ofs_q_vld` is 0.
- R2: A store takes place on a rising `wclk` when `load_n`=0 and `wen_n`=0. It copies `wdata[OFS_W-1:0]` into the register chosen by the load pointer. The first store after reset writes `empty_ofs`, the next writes `full_ofs`, and the two alternate from then on. Both output ports show the new value after that edge.
- R3: After a store to `full_ofs`, the load pointer wraps back to `empty_ofs`. Reset returns both the load pointer and the readback pointer to `empty_ofs`.
- R4: A store ignores `wdata` bits at OFS_W and above. Readback drives `ofs_q` bits at OFS_W and above to zero.
- R5: A readback takes place on a rising `rclk` when `load_n`=0, `ren_n`=0 and `fwft_mode`=0. At that edge `ofs_q` takes the offset chosen by the readback pointer and `ofs_q_vld` goes to 1 for the cycle. The first readback presents `empty_ofs` and the next presents `full_ofs`.
- R6: The readback pointer alternates without limit, so a third consecutive readback presents `empty_ofs` again.
- R7: While `fwft_mode`=1, read strobes during select are ignored. `ofs_q_vld` stays 0 and the readback pointer does not move.
- R8: `mem_we` equals `!wen_n && load_n`. `mem_re` equals `!ren_n && load_n`. Both qualifiers are therefore 0 whenever `load_n`=0.
- R9: When `wen_n`=1, no store takes place even if `load_n`=0. The offsets and the load pointer keep their values.
- R10: In a cycle with no readback, `ofs_q_vld` is 0 and `ofs_q` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| load_n | input | 1 | Active-low offset access select |
| wen_n | input | 1 | Active-low write strobe |
| ren_n | input | 1 | Active-low read strobe |
| fwft_mode | input | 1 | 1 selects first-word-fall-through mode, which blocks readback |
| wdata | input | DATA_W | FIFO write data bus |
| ofs_q | output | DATA_W | Registered offset readback value |
| ofs_q_vld | output | 1 | High for the cycle in which `ofs_q` carries a new readback |
| empty_ofs | output | OFS_W | Current almost-empty offset `n` |
| full_ofs | output | OFS_W | Current almost-full offset `m` |
| mem_we | output | 1 | Qualified FIFO memory write enable |
| mem_re | output | 1 | Qualified FIFO memory read enable |

## Verification
The bench builds the block with DEPTH=512, DATA_W=18 and OFS_W=12. This gives a reset default of 63, which differs from every value the bench stores, so a missed store or a missed reset is visible. An 18-bit bus with a 12-bit offset field leaves six upper bits on which the bench checks masking and zero fill. The two clocks run at the same rate with a quarter-period skew, which allows readback runs of three accesses to exercise pointer wrap. Resetting in the middle of a sequence, after both pointers have moved, shows that reset rewinds them.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  typedef enum logic {
    SEL_EMPTY = 1'b0,
    SEL_FULL  = 1'b1
  } ofs_sel_e;

  // Default threshold distance: one eighth of the depth less one, capped at 127.
  function automatic int unsigned default_offset(input int unsigned depth);
    int unsigned v;
    v = (depth / 8) - 1;
    return (v > 127) ? 127 : v;
  endfunction

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction

endpackage

// File: rtl/ofs_load_path.sv
module ofs_load_path
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic [OFS_W-1:0] wfield,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);

  localparam logic [OFS_W-1:0] RST_OFS = OFS_W'(default_offset(DEPTH));

  ofs_sel_e load_ptr;
  logic     store;

  assign store = !load_n && !wen_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_ptr  <= SEL_EMPTY;
      empty_ofs <= RST_OFS;
      full_ofs  <= RST_OFS;
    end else if (store) begin
      if (load_ptr == SEL_EMPTY) begin
        empty_ofs <= wfield;
      end else begin
        full_ofs <= wfield;
      end
      load_ptr <= next_sel(load_ptr);
    end
  end

endmodule

// File: rtl/ofs_readback_path.sv
module ofs_readback_path
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              ren_n,
  input  logic              fwft_mode,
  input  logic [OFS_W-1:0]  empty_ofs,
  input  logic [OFS_W-1:0]  full_ofs,
  output logic [DATA_W-1:0] ofs_q,
  output logic              ofs_q_vld
);

  ofs_sel_e         rd_ptr;
  logic             rd_go;
  logic [OFS_W-1:0] rd_sel_val;

  assign rd_go      = !load_n && !ren_n && !fwft_mode;
  assign rd_sel_val = (rd_ptr == SEL_EMPTY) ? empty_ofs : full_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= SEL_EMPTY;
      ofs_q     <= '0;
      ofs_q_vld <= 1'b0;
    end else begin
      ofs_q_vld <= rd_go;
      if (rd_go) begin
        ofs_q  <= DATA_W'(rd_sel_val);
        rd_ptr <= next_sel(rd_ptr);
      end
    end
  end

endmodule

// File: rtl/ofs_access_gate.sv
module ofs_access_gate (
  input  logic load_n,
  input  logic wen_n,
  input  logic ren_n,
  output logic mem_we,
  output logic mem_re
);

  always_comb begin
    mem_we = !wen_n && load_n;
    mem_re = !ren_n && load_n;
  end

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 12
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic              fwft_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ofs_q,
  output logic              ofs_q_vld,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              mem_we,
  output logic              mem_re
);

  generate
    if (DATA_W > OFS_W) begin : g_hi_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:OFS_W];
    end
  endgenerate

  ofs_load_path #(
    .DEPTH (DEPTH),
    .OFS_W (OFS_W)
  ) u_load (
    .clk       (wclk),
    .rst       (rst),
    .load_n    (load_n),
    .wen_n     (wen_n),
    .wfield    (wdata[OFS_W-1:0]),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  ofs_readback_path #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_readback (
    .clk       (rclk),
    .rst       (rst),
    .load_n    (load_n),
    .ren_n     (ren_n),
    .fwft_mode (fwft_mode),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .ofs_q     (ofs_q),
    .ofs_q_vld (ofs_q_vld)
  );

  ofs_access_gate u_gate (
    .load_n (load_n),
    .wen_n  (wen_n),
    .ren_n  (ren_n),
    .mem_we (mem_we),
    .mem_re (mem_re)
  );

endmodule

// File: rtl/flag_offset_regs_chk.sv
module flag_offset_regs_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 12
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst,
  input logic              load_n,
  input logic              wen_n,
  input logic              ren_n,
  input logic              fwft_mode,
  input logic [DATA_W-1:0] ofs_q,
  input logic              ofs_q_vld,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs,
  input logic              mem_we,
  input logic              mem_re
);

  // R2
  one_reg_per_store_chk: assert property (@(posedge wclk) disable iff (rst)
    (!load_n && !wen_n) |=> ($stable(empty_ofs) || $stable(full_ofs)));

  // R9
  no_store_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    (load_n || wen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R5
  vld_needs_request_chk: assert property (@(posedge rclk) disable iff (rst)
    ofs_q_vld |-> $past(!load_n && !ren_n && !fwft_mode));

  // R7
  fwft_blocks_readback_chk: assert property (@(posedge rclk) disable iff (rst)
    fwft_mode |=> !ofs_q_vld);

  // R4
  upper_bits_zero_chk: assert property (@(posedge rclk) disable iff (rst)
    ofs_q_vld |-> ((ofs_q >> OFS_W) == '0));

  // R10
  q_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    !ofs_q_vld |=> (ofs_q_vld || $stable(ofs_q)));

  always_comb begin
    if (!load_n) begin
      // R8
      mem_gate_chk: assert (!mem_we && !mem_re);
    end
  end

endmodule

bind flag_offset_regs flag_offset_regs_chk #(
  .DATA_W (DATA_W),
  .OFS_W  (OFS_W)
) u_chk (
  .wclk      (wclk),
  .rclk      (rclk),
  .rst       (rst),
  .load_n    (load_n),
  .wen_n     (wen_n),
  .ren_n     (ren_n),
  .fwft_mode (fwft_mode),
  .ofs_q     (ofs_q),
  .ofs_q_vld (ofs_q_vld),
  .empty_ofs (empty_ofs),
  .full_ofs  (full_ofs),
  .mem_we    (mem_we),
  .mem_re    (mem_re)
);

// File: tb/flag_offset_regs_tb.sv
module flag_offset_regs_tb;

  localparam int DEPTH  = 512;
  localparam int DATA_W = 18;
  localparam int OFS_W  = 12;
  localparam logic [OFS_W-1:0] DEF = 12'd63;

  logic              wclk = 1'b0;
  logic              rclk = 1'b0;
  logic              rst = 1'b1;
  logic              load_n = 1'b1;
  logic              wen_n = 1'b1;
  logic              ren_n = 1'b1;
  logic              fwft_mode = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] ofs_q;
  logic              ofs_q_vld;
  logic [OFS_W-1:0]  empty_ofs;
  logic [OFS_W-1:0]  full_ofs;
  logic              mem_we;
  logic              mem_re;

  flag_offset_regs #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_dut (
    .wclk      (wclk),
    .rclk      (rclk),
    .rst       (rst),
    .load_n    (load_n),
    .wen_n     (wen_n),
    .ren_n     (ren_n),
    .fwft_mode (fwft_mode),
    .wdata     (wdata),
    .ofs_q     (ofs_q),
    .ofs_q_vld (ofs_q_vld),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

  always #10 wclk = ~wclk;
  initial begin
    #5;
    forever #10 rclk = ~rclk;
  end

  int n_chk = 0;
  int n_err = 0;
  logic [DATA_W-1:0] exp_q[$];

  logic [OFS_W-1:0] m_empty = DEF;
  logic [OFS_W-1:0] m_full  = DEF;
  bit m_lptr = 1'b0;
  bit m_rptr = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every readback pulse must match the head of the scoreboard.
  always @(posedge rclk) begin
    #1;
    if (!rst && ofs_q_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected readback", 32'(ofs_q), 32'h0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(ofs_q == e, "R5 readback value", 32'(ofs_q), 32'(e));
      end
    end
  end

  task automatic do_reset();
    @(negedge wclk);
    rst = 1'b1;
    repeat (3) @(negedge wclk);
    rst = 1'b0;
    m_empty = DEF;
    m_full  = DEF;
    m_lptr  = 1'b0;
    m_rptr  = 1'b0;
  endtask

  task automatic load_ofs(input logic [DATA_W-1:0] v);
    @(negedge wclk);
    load_n = 1'b0;
    wen_n  = 1'b0;
    wdata  = v;
    #1;
    chk(mem_we == 1'b0, "R8 mem_we during store", 32'(mem_we), 32'h0);
    if (!m_lptr) m_empty = v[OFS_W-1:0];
    else         m_full  = v[OFS_W-1:0];
    m_lptr = ~m_lptr;
    @(negedge wclk);
    load_n = 1'b1;
    wen_n  = 1'b1;
  endtask

  task automatic read_ofs(input int k, input bit fw);
    @(negedge rclk);
    fwft_mode = fw;
    load_n = 1'b0;
    ren_n  = 1'b0;
    for (int i = 0; i < k; i++) begin
      if (!fw) begin
        exp_q.push_back(DATA_W'(m_rptr ? m_full : m_empty));
        m_rptr = ~m_rptr;
      end
      @(negedge rclk);
      if (fw) chk(ofs_q_vld == 1'b0, "R7 no readback in fwft", 32'(ofs_q_vld), 32'h0);
    end
    load_n = 1'b1;
    ren_n  = 1'b1;
    fwft_mode = 1'b0;
    @(negedge rclk);
  endtask

  task automatic chk_ports(input string req);
    chk(empty_ofs == m_empty, req, 32'(empty_ofs), 32'(m_empty));
    chk(full_ofs == m_full, req, 32'(full_ofs), 32'(m_full));
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge rclk);
    chk_ports("R1 reset default");
    chk(ofs_q_vld == 1'b0, "R1 vld after reset", 32'(ofs_q_vld), 32'h0);
    chk(ofs_q == '0, "R1 q after reset", 32'(ofs_q), 32'h0);

    // R1: readback of the defaults
    read_ofs(2, 1'b0);

    // R2: alternate stores
    load_ofs(18'h00010);
    chk_ports("R2 first store");
    load_ofs(18'h007F0);
    chk_ports("R2 second store");

    // R3 and R4: wrap to empty, upper bits masked
    load_ofs(18'h3F123);
    chk_ports("R3 R4 wrap store");

    // R9: select with write strobe off
    @(negedge wclk);
    load_n = 1'b0;
    wen_n  = 1'b1;
    wdata  = 18'h00ABC;
    repeat (2) @(negedge wclk);
    load_n = 1'b1;
    chk_ports("R9 no store without strobe");
    load_ofs(18'h00055);
    chk_ports("R9 pointer kept");

    // R6: three readbacks wrap
    read_ofs(3, 1'b0);

    // R7: fwft blocks readback and keeps pointer
    read_ofs(2, 1'b1);
    read_ofs(1, 1'b0);

    // R10: output holds
    repeat (2) @(negedge rclk);
    chk(ofs_q_vld == 1'b0, "R10 vld idle", 32'(ofs_q_vld), 32'h0);
    chk(ofs_q == DATA_W'(m_full), "R10 q hold", 32'(ofs_q), 32'(m_full));

    // R8: qualifiers
    @(negedge wclk);
    wen_n = 1'b0;
    ren_n = 1'b0;
    #1;
    chk(mem_we == 1'b1, "R8 mem_we pass", 32'(mem_we), 32'h1);
    chk(mem_re == 1'b1, "R8 mem_re pass", 32'(mem_re), 32'h1);
    load_n = 1'b0;
    wen_n  = 1'b1;
    #1;
    chk(mem_re == 1'b0, "R8 mem_re gated", 32'(mem_re), 32'h0);
    load_n = 1'b1;
    ren_n  = 1'b1;
    exp_q.delete();
    @(negedge rclk);
    @(negedge rclk);

    // R3: reset rewinds both pointers
    load_ofs(18'h00111);
    read_ofs(1, 1'b0);
    do_reset();
    load_ofs(18'h00222);
    chk_ports("R3 pointer after reset");
    read_ofs(1, 1'b0);

    repeat (4) @(negedge rclk);
    chk(exp_q.size() == 0, "R5 all readbacks seen", 32'(exp_q.size()), 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule